// File: doc/BRIEF.md
# Multiple-Bus Memory Access Arbiter

This block decides, every clock cycle, which processors may reach a memory module and over which of several parallel shared buses they do so. Each processor presents a request, the number of the memory module it wants and a read/write flag. The arbiter hands out at most one bus per processor, never puts two processors on the same bus, and never lets two processors reach the same memory module in the same cycle. A processor that is not served keeps its request up and retries in a later cycle.

The buses that a memory module may use depend on a selectable connection scheme. In the first scheme every module sits on every bus. In the second each module is wired to one bus. In the third each module has its own writable set of buses. In the fourth each module belongs to a class and uses the set of buses of that class. Each bus also has a fault input, and a faulted bus is left out of allocation so that the other buses keep working. Grants and bus assignments are registered and appear one cycle after the request. Priority between processors rotates so that every requester gets its turn. Data transfer, caches and memory timing are outside this block.

Top module: `mbus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `gnt_o` and `bus_act_o` are all zero. The rotating priority pointer starts at processor 0.
- R2: No bus is given to more than one processor in a cycle. `bus_act_o` has exactly the bits of the buses used by granted processors set, and `gnt_bus_o` is zero for a processor that is not granted.
- R3: No two processors granted in the same cycle target the same memory module.
- R4: A bus whose bit in `bus_fault_i` is 1 in a cycle is never assigned by the grants that cycle produces.
- R5: With `cfg_mode_i` = 0 (full scheme), any memory module may use any bus that is not faulted.
- R6: With `cfg_mode_i` = 1 (single scheme), memory module m may use only bus (m mod N_BUS).
- R7: With `cfg_mode_i` = 2 (partial scheme), memory module m may use only the buses whose bits are 1 in its own bus set. That set is written with `cfg_we_i`=1, `cfg_sel_i`=0, `cfg_idx_i`=m and `cfg_row_i` = the set, with bit b standing for bus b. Every set resets to all ones.
- R8: With `cfg_mode_i` = 3 (class scheme), memory module m may use only the bus set of its class. The bus set of class k is written with `cfg_sel_i`=1, `cfg_idx_i`=k and `cfg_row_i`. The class of module m is written with `cfg_sel_i`=2, `cfg_idx_i`=m and `cfg_cls_i`. Classes reset to 0 and class bus sets reset to all ones. A configuration write takes effect from the next cycle.
- R9: Allocation takes one cycle. Processors are visited in order, starting at the priority pointer and wrapping at N_PROC. A visited processor is granted if it requests, its module is still free, and a free, usable, non-faulted bus exists. It receives the lowest-numbered such bus. Other requests are not granted in that cycle.
- R10: After a cycle with at least one grant, the priority pointer moves to one past the first processor granted in visiting order, wrapping at N_PROC. After a cycle with no grant it stays where it is.
- R11: For each active bus b, `bus_wr_o[b]` and `bus_mod_o` field b carry the read/write flag and module number of the processor granted that bus. They are zero for an inactive bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_i | input | 2 | Connection scheme: 0 full, 1 single, 2 partial, 3 class |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write target: 0 module bus set, 1 class bus set, 2 module class; 3 ignored |
| cfg_idx_i | input | IW | Module or class index of the write |
| cfg_row_i | input | N_BUS | Bus set written (bit b = bus b) |
| cfg_cls_i | input | KW | Class number written for a module |
| bus_fault_i | input | N_BUS | Per-bus fault mask, 1 = bus unusable |
| req_i | input | N_PROC | Per-processor request |
| req_mod_i | input | N_PROC*MW | Target module per processor, field p at bits p*MW |
| req_wr_i | input | N_PROC | Per-processor write flag |
| gnt_o | output | N_PROC | Per-processor grant, registered |
| gnt_bus_o | output | N_PROC*BW | Assigned bus per processor, field p at bits p*BW |
| bus_act_o | output | N_BUS | Bus carries a granted transfer |
| bus_wr_o | output | N_BUS | Write flag of the bus owner |
| bus_mod_o | output | N_BUS*MW | Module addressed on each bus, field b at bits b*MW |

## Verification
The assertions take the request, module and fault inputs as stable around the clock edge. They also assume that every module number on `req_mod_i` names an existing module, which always holds with a power-of-two module count. Several of them look one cycle into the past to pair a registered grant with the inputs that produced it. The bench changes inputs only a fixed delay after a rising edge and holds them for a whole cycle. It draws module numbers only from the valid range and steps through all sixteen fault masks under each of the four schemes. It writes configuration only in cycles where no processor requests, so no grant depends on a write landing in the same cycle.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

   // connection scheme between memory modules and buses
   typedef enum logic [1:0] {
      MODE_FULL    = 2'd0,
      MODE_SINGLE  = 2'd1,
      MODE_PARTIAL = 2'd2,
      MODE_CLASS   = 2'd3
   } conn_mode_e;

   // target of a configuration write
   typedef enum logic [1:0] {
      WR_ROW        = 2'd0,
      WR_CLASS_MASK = 2'd1,
      WR_MOD_CLASS  = 2'd2,
      WR_NONE       = 2'd3
   } cfg_sel_e;

   // index width, never below one bit
   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mbus_conn_map.sv
module mbus_conn_map
   import mbus_pkg::*;
#(
   parameter int unsigned N_MEM   = 4,
   parameter int unsigned N_BUS   = 4,
   parameter int unsigned N_CLASS = 2,
   localparam int unsigned MW = idx_w(N_MEM),
   localparam int unsigned KW = idx_w(N_CLASS),
   localparam int unsigned IW = (MW > KW) ? MW : KW
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  conn_mode_e               mode_i,
   input  logic                     cfg_we_i,
   input  cfg_sel_e                 cfg_sel_i,
   input  logic [IW-1:0]            cfg_idx_i,
   input  logic [N_BUS-1:0]         cfg_row_i,
   input  logic [KW-1:0]            cfg_cls_i,
   input  logic [N_BUS-1:0]         bus_fault_i,
   output logic [N_MEM*N_BUS-1:0]   conn_o,
   output logic [N_MEM*N_BUS-1:0]   usable_o
);

   logic [N_CLASS*N_BUS-1:0] cmask_flat;

   // per-class bus sets (R8)
   for (genvar k = 0; k < N_CLASS; k++) begin : g_cls
      logic [N_BUS-1:0] mask_q;
      logic             mask_we;
      assign mask_we = cfg_we_i && (cfg_sel_i == WR_CLASS_MASK) &&
                       (cfg_idx_i == IW'(k));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       mask_q <= '1;
         else if (mask_we) mask_q <= cfg_row_i;
      end
      assign cmask_flat[k*N_BUS +: N_BUS] = mask_q;
   end

   // per-module storage and scheme selection (R5 R6 R7 R8)
   for (genvar m = 0; m < N_MEM; m++) begin : g_mod
      logic [N_BUS-1:0] row_q;
      logic [KW-1:0]    cls_q;
      logic             row_we, cls_we;
      logic [N_BUS-1:0] single_row, class_row, sel_row;

      assign row_we = cfg_we_i && (cfg_sel_i == WR_ROW) &&
                      (cfg_idx_i == IW'(m));
      assign cls_we = cfg_we_i && (cfg_sel_i == WR_MOD_CLASS) &&
                      (cfg_idx_i == IW'(m)) && (32'(cfg_cls_i) < N_CLASS);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            row_q <= '1;
            cls_q <= '0;
         end else begin
            if (row_we) row_q <= cfg_row_i;
            if (cls_we) cls_q <= cfg_cls_i;
         end
      end

      assign single_row = N_BUS'(1) << (m % N_BUS);
      assign class_row  = cmask_flat[32'(cls_q)*N_BUS +: N_BUS];

      always_comb begin
         case (mode_i)
            MODE_FULL:    sel_row = '1;
            MODE_SINGLE:  sel_row = single_row;
            MODE_PARTIAL: sel_row = row_q;
            default:      sel_row = class_row;
         endcase
      end

      assign conn_o[m*N_BUS +: N_BUS]   = sel_row;
      assign usable_o[m*N_BUS +: N_BUS] = sel_row & ~bus_fault_i;

      // a_r8_class_range: stored class always names an existing class (R8)
      a_r8_class_range: assert property (@(posedge clk) disable iff (!rst_n)
         32'(cls_q) < N_CLASS);
   end

endmodule

// File: rtl/mbus_alloc.sv
module mbus_alloc
   import mbus_pkg::*;
#(
   parameter int unsigned N_PROC = 6,
   parameter int unsigned N_MEM  = 4,
   parameter int unsigned N_BUS  = 4,
   localparam int unsigned PW = idx_w(N_PROC),
   localparam int unsigned MW = idx_w(N_MEM),
   localparam int unsigned BW = idx_w(N_BUS)
) (
   input  logic [N_PROC-1:0]       req_i,
   input  logic [N_PROC*MW-1:0]    mod_i,
   input  logic [N_MEM*N_BUS-1:0]  usable_i,
   input  logic [PW-1:0]           ptr_i,
   output logic [N_PROC-1:0]       gnt_o,
   output logic [N_PROC*BW-1:0]    gbus_o,
   output logic [N_BUS-1:0]        bus_used_o,
   output logic [N_BUS*PW-1:0]     bus_owner_o,
   output logic                    adv_o,
   output logic [PW-1:0]           nxt_o
);

   // greedy visit in rotating order, lowest free usable bus first (R9)
   always_comb begin
      logic [N_MEM-1:0] mod_busy;
      int               p;
      int               mi;
      logic             placed;
      gnt_o       = '0;
      gbus_o      = '0;
      bus_used_o  = '0;
      bus_owner_o = '0;
      adv_o       = 1'b0;
      nxt_o       = '0;
      mod_busy    = '0;
      for (int k = 0; k < N_PROC; k++) begin
         p = int'(ptr_i) + k;
         if (p >= N_PROC) p = p - N_PROC;
         mi     = int'(mod_i[p*MW +: MW]);
         placed = 1'b0;
         if (req_i[p] && (mi < N_MEM)) begin
            if (!mod_busy[mi]) begin
               for (int b = 0; b < N_BUS; b++) begin
                  if (!placed && !bus_used_o[b] && usable_i[mi*N_BUS + b]) begin
                     placed                  = 1'b1;
                     bus_used_o[b]           = 1'b1;
                     bus_owner_o[b*PW +: PW] = PW'(p);
                     gbus_o[p*BW +: BW]      = BW'(b);
                     gnt_o[p]                = 1'b1;
                  end
               end
               if (placed) begin
                  mod_busy[mi] = 1'b1;
                  if (!adv_o) begin
                     adv_o = 1'b1;
                     nxt_o = (p == N_PROC - 1) ? '0 : PW'(p + 1);
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/mbus_rr_ptr.sv
module mbus_rr_ptr
   import mbus_pkg::*;
#(
   parameter int unsigned N_PROC = 6,
   localparam int unsigned PW = idx_w(N_PROC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_i,
   input  logic [PW-1:0] nxt_i,
   output logic [PW-1:0] ptr_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_o <= '0;
      else if (adv_i) ptr_o <= nxt_i;
   end

   // a_r10_hold_idle: pointer unchanged after a cycle with no grant (R10)
   a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(ptr_o));

   // a_r10_in_range: pointer always names an existing processor (R10)
   a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ptr_o) < N_PROC);

endmodule

// File: rtl/mbus_arbiter.sv
module mbus_arbiter
   import mbus_pkg::*;
#(
   parameter int unsigned N_PROC  = 6,
   parameter int unsigned N_MEM   = 4,
   parameter int unsigned N_BUS   = 4,
   parameter int unsigned N_CLASS = 2,
   localparam int unsigned PW = idx_w(N_PROC),
   localparam int unsigned MW = idx_w(N_MEM),
   localparam int unsigned BW = idx_w(N_BUS),
   localparam int unsigned KW = idx_w(N_CLASS),
   localparam int unsigned IW = (MW > KW) ? MW : KW
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              cfg_mode_i,
   input  logic                    cfg_we_i,
   input  logic [1:0]              cfg_sel_i,
   input  logic [IW-1:0]           cfg_idx_i,
   input  logic [N_BUS-1:0]        cfg_row_i,
   input  logic [KW-1:0]           cfg_cls_i,
   input  logic [N_BUS-1:0]        bus_fault_i,
   input  logic [N_PROC-1:0]       req_i,
   input  logic [N_PROC*MW-1:0]    req_mod_i,
   input  logic [N_PROC-1:0]       req_wr_i,
   output logic [N_PROC-1:0]       gnt_o,
   output logic [N_PROC*BW-1:0]    gnt_bus_o,
   output logic [N_BUS-1:0]        bus_act_o,
   output logic [N_BUS-1:0]        bus_wr_o,
   output logic [N_BUS*MW-1:0]     bus_mod_o
);

   // elaboration-time parameter checks
   if (N_PROC < 2)   begin : g_bad_proc  $error("N_PROC must be at least 2");  end
   if (N_MEM < 2)    begin : g_bad_mem   $error("N_MEM must be at least 2");   end
   if (N_BUS < 1)    begin : g_bad_bus   $error("N_BUS must be at least 1");   end
   if (N_CLASS < 1)  begin : g_bad_class $error("N_CLASS must be at least 1"); end

   logic [N_MEM*N_BUS-1:0] conn_w, usable_w;
   logic [PW-1:0]          ptr_w, nxt_w;
   logic                   adv_w;
   logic [N_PROC-1:0]      gnt_n;
   logic [N_PROC*BW-1:0]   gbus_n;
   logic [N_BUS-1:0]       used_n;
   logic [N_BUS*PW-1:0]    owner_n;
   logic [N_BUS-1:0]       wr_n;
   logic [N_BUS*MW-1:0]    mod_n;

   mbus_conn_map #(
      .N_MEM   (N_MEM),
      .N_BUS   (N_BUS),
      .N_CLASS (N_CLASS)
   ) u_map (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (conn_mode_e'(cfg_mode_i)),
      .cfg_we_i    (cfg_we_i),
      .cfg_sel_i   (cfg_sel_e'(cfg_sel_i)),
      .cfg_idx_i   (cfg_idx_i),
      .cfg_row_i   (cfg_row_i),
      .cfg_cls_i   (cfg_cls_i),
      .bus_fault_i (bus_fault_i),
      .conn_o      (conn_w),
      .usable_o    (usable_w)
   );

   mbus_alloc #(
      .N_PROC (N_PROC),
      .N_MEM  (N_MEM),
      .N_BUS  (N_BUS)
   ) u_alloc (
      .req_i       (req_i),
      .mod_i       (req_mod_i),
      .usable_i    (usable_w),
      .ptr_i       (ptr_w),
      .gnt_o       (gnt_n),
      .gbus_o      (gbus_n),
      .bus_used_o  (used_n),
      .bus_owner_o (owner_n),
      .adv_o       (adv_w),
      .nxt_o       (nxt_w)
   );

   mbus_rr_ptr #(
      .N_PROC (N_PROC)
   ) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (adv_w),
      .nxt_i (nxt_w),
      .ptr_o (ptr_w)
   );

   // per-bus owner attributes (R11)
   for (genvar b = 0; b < N_BUS; b++) begin : g_bus
      logic [PW-1:0] own;
      assign own                 = owner_n[b*PW +: PW];
      assign wr_n[b]             = used_n[b] & req_wr_i[own];
      assign mod_n[b*MW +: MW]   = used_n[b] ? req_mod_i[32'(own)*MW +: MW] : '0;
   end

   // one-cycle registered result (R1 R9)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_o     <= '0;
         gnt_bus_o <= '0;
         bus_act_o <= '0;
         bus_wr_o  <= '0;
         bus_mod_o <= '0;
      end else begin
         gnt_o     <= gnt_n;
         gnt_bus_o <= gbus_n;
         bus_act_o <= used_n;
         bus_wr_o  <= wr_n;
         bus_mod_o <= mod_n;
      end
   end

   // a_r2_bus_count: active buses match granted processors (R2)
   a_r2_bus_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bus_act_o) == $countones(gnt_o));

   for (genvar p = 0; p < N_PROC; p++) begin : g_chk
      // a_r4_healthy_bus: granted bus was not faulted (R4)
      a_r4_healthy_bus: assert property (@(posedge clk) disable iff (!rst_n)
         gnt_o[p] |-> ((($past(bus_fault_i) >> gnt_bus_o[p*BW +: BW]) & N_BUS'(1)) == '0));

      // a_r6_map_respected: granted bus is in the module's map (R5 R6 R7 R8)
      a_r6_map_respected: assert property (@(posedge clk) disable iff (!rst_n)
         gnt_o[p] |-> ((($past(conn_w) >> (32'($past(req_mod_i[p*MW +: MW]))*N_BUS
            + 32'(gnt_bus_o[p*BW +: BW]))) & (N_MEM*N_BUS)'(1)) != '0));

      // a_r11_bus_mirror: granted bus carries the processor's flag (R11)
      a_r11_bus_mirror: assert property (@(posedge clk) disable iff (!rst_n)
         gnt_o[p] |-> (bus_act_o[gnt_bus_o[p*BW +: BW]] &&
                       bus_wr_o[gnt_bus_o[p*BW +: BW]] == $past(req_wr_i[p])));

      // a_r2_idle_zero: no bus index reported for an idle processor (R2)
      a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !gnt_o[p] |-> (gnt_bus_o[p*BW +: BW] == '0));

      for (genvar q = p + 1; q < N_PROC; q++) begin : g_pair
         // a_r2_bus_distinct: two grants never share a bus (R2)
         a_r2_bus_distinct: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_o[p] && gnt_o[q]) |-> (gnt_bus_o[p*BW +: BW] != gnt_bus_o[q*BW +: BW]));

         // a_r3_mod_distinct: two grants never share a module (R3)
         a_r3_mod_distinct: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_o[p] && gnt_o[q]) |->
               ($past(req_mod_i[p*MW +: MW]) != $past(req_mod_i[q*MW +: MW])));
      end
   end

endmodule

// File: tb/mbus_arbiter_tb_top.sv
module mbus_arbiter_tb_top;
   localparam int NP = 6, NM = 4, NB = 4, NK = 2;
   localparam int MW = 2, BW = 2, KW = 1, IW = 2;

   logic            clk, rst_n;
   logic [1:0]      cfg_mode, cfg_sel;
   logic            cfg_we;
   logic [IW-1:0]   cfg_idx;
   logic [NB-1:0]   cfg_row, fault;
   logic [KW-1:0]   cfg_cls;
   logic [NP-1:0]   req, req_wr;
   logic [NP*MW-1:0] req_mod;
   logic [NP-1:0]   gnt_o;
   logic [NP*BW-1:0] gnt_bus_o;
   logic [NB-1:0]   bus_act_o, bus_wr_o;
   logic [NB*MW-1:0] bus_mod_o;

   mbus_arbiter #(.N_PROC(NP), .N_MEM(NM), .N_BUS(NB), .N_CLASS(NK)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_mode_i(cfg_mode), .cfg_we_i(cfg_we),
      .cfg_sel_i(cfg_sel), .cfg_idx_i(cfg_idx), .cfg_row_i(cfg_row),
      .cfg_cls_i(cfg_cls), .bus_fault_i(fault), .req_i(req),
      .req_mod_i(req_mod), .req_wr_i(req_wr), .gnt_o(gnt_o),
      .gnt_bus_o(gnt_bus_o), .bus_act_o(bus_act_o), .bus_wr_o(bus_wr_o),
      .bus_mod_o(bus_mod_o));

   initial clk = 1'b0;
   always #5 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   int mptr = 0;
   logic [NB-1:0] m_row [NM];
   int            m_cls [NM];
   logic [NB-1:0] m_mask [NK];
   logic [31:0]   rs = 32'h2468_ace1;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rnd();
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      return rs;
   endfunction

   function automatic bit ok_map(int m, int b);
      case (cfg_mode)
         2'd0: return 1'b1;
         2'd1: return b == (m % NB);
         2'd2: return m_row[m][b];
         default: return m_mask[m_cls[m]][b];
      endcase
   endfunction

   function automatic string mtag();
      case (cfg_mode)
         2'd0: return "R5";
         2'd1: return "R6";
         2'd2: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic step(input logic [NP-1:0] rq, input logic [NP*MW-1:0] md,
                       input logic [NP-1:0] wr);
      logic [NP-1:0] e_gnt;
      logic [NB-1:0] e_act;
      int            e_bus [NP];
      int            e_own [NB];
      logic [NM-1:0] busy;
      int            e_nxt;
      bit            adv;
      req = rq; req_mod = md; req_wr = wr;
      e_gnt = '0; e_act = '0; busy = '0; adv = 0; e_nxt = 0;
      for (int i = 0; i < NP; i++) e_bus[i] = 0;
      for (int i = 0; i < NB; i++) e_own[i] = 0;
      for (int k = 0; k < NP; k++) begin
         int p, m;
         bit done;
         p = (mptr + k) % NP;
         m = int'(md[p*MW +: MW]);
         done = 0;
         if (rq[p] && !busy[m]) begin
            for (int b = 0; b < NB; b++) begin
               if (!done && !e_act[b] && !fault[b] && ok_map(m, b)) begin
                  done = 1; e_act[b] = 1'b1; e_bus[p] = b; e_own[b] = p; e_gnt[p] = 1'b1;
               end
            end
            if (done) begin
               busy[m] = 1'b1;
               if (!adv) begin adv = 1; e_nxt = (p + 1) % NP; end
            end
         end
      end
      @(posedge clk); #1;
      chk("R9 grant vector", 64'(gnt_o), 64'(e_gnt));
      chk("R2 active buses", 64'(bus_act_o), 64'(e_act));
      for (int p = 0; p < NP; p++) begin
         if (e_gnt[p]) chk("R9 bus index", 64'(gnt_bus_o[p*BW +: BW]), 64'(e_bus[p]));
         else          chk("R2 idle index", 64'(gnt_bus_o[p*BW +: BW]), 64'd0);
         if (gnt_o[p]) begin
            int gb, gm;
            gb = int'(gnt_bus_o[p*BW +: BW]);
            gm = int'(md[p*MW +: MW]);
            chk(mtag(), 64'(ok_map(gm, gb)), 64'd1);
            chk("R4 faulted bus", 64'(fault[gb]), 64'd0);
         end
      end
      for (int m = 0; m < NM; m++) begin
         int c;
         c = 0;
         for (int p = 0; p < NP; p++)
            if (gnt_o[p] && int'(md[p*MW +: MW]) == m) c++;
         chk("R3 module once", 64'(c <= 1), 64'd1);
      end
      for (int b = 0; b < NB; b++) begin
         if (e_act[b]) begin
            chk("R11 write flag", 64'(bus_wr_o[b]), 64'(wr[e_own[b]]));
            chk("R11 module", 64'(bus_mod_o[b*MW +: MW]), 64'(md[e_own[b]*MW +: MW]));
         end else begin
            chk("R11 idle flag", 64'(bus_wr_o[b]), 64'd0);
            chk("R11 idle module", 64'(bus_mod_o[b*MW +: MW]), 64'd0);
         end
      end
      if (adv) mptr = e_nxt;
   endtask

   task automatic cfg_wr(input logic [1:0] sel, input int idx, input logic [NB-1:0] row,
                         input int cls);
      req = '0; cfg_we = 1'b1; cfg_sel = sel; cfg_idx = IW'(idx);
      cfg_row = row; cfg_cls = KW'(cls);
      @(posedge clk); #1;
      cfg_we = 1'b0;
      if (sel == 2'd0) m_row[idx] = row;
      else if (sel == 2'd1) m_mask[idx] = row;
      else if (sel == 2'd2) m_cls[idx] = cls;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #1_500_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_mode = 2'd0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_idx = '0;
      cfg_row = '0; cfg_cls = '0; fault = '0; req = '0; req_mod = '0; req_wr = '0;
      for (int m = 0; m < NM; m++) begin m_row[m] = '1; m_cls[m] = 0; end
      for (int k = 0; k < NK; k++) m_mask[k] = '1;
      // requests held up during reset must not show (R1)
      req = '1;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset grants", 64'(gnt_o), 64'd0);
      chk("R1 reset buses", 64'(bus_act_o), 64'd0);
      req = '0;
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 first cycle grants", 64'(gnt_o), 64'd0);
      chk("R1 first cycle buses", 64'(bus_act_o), 64'd0);

      // R10: all processors want module 0, priority walks from processor 0
      for (int i = 0; i < 8; i++) begin
         step('1, '0, '0);
         chk("R10 rotation", 64'(gnt_o), 64'(1 << (i % NP)));
      end
      // R10: every bus faulted, nothing granted, pointer holds
      fault = '1;
      for (int i = 0; i < 3; i++) step('1, '0, '0);
      fault = '0;
      step('1, '0, '0);
      chk("R10 hold after idle", 64'(gnt_o), 64'(1 << (8 % NP)));

      // R7 and R8 configuration
      cfg_wr(2'd0, 0, 4'b0011, 0);
      cfg_wr(2'd0, 1, 4'b0110, 0);
      cfg_wr(2'd0, 2, 4'b1100, 0);
      cfg_wr(2'd0, 3, 4'b1000, 0);
      cfg_wr(2'd1, 0, 4'b0101, 0);
      cfg_wr(2'd1, 1, 4'b1010, 0);
      cfg_wr(2'd2, 1, 4'b0000, 1);
      cfg_wr(2'd2, 2, 4'b0000, 1);
      cfg_wr(2'd3, 0, 4'b0000, 0);  // ignored target

      // sweep all schemes and all fault masks with pseudo-random traffic
      for (int md = 0; md < 4; md++) begin
         cfg_mode = 2'(md);
         for (int f = 0; f < 16; f++) begin
            fault = 4'(f);
            for (int s = 0; s < 24; s++) begin
               logic [31:0] r;
               r = rnd();
               step(r[5:0] | ((s % 5 == 0) ? 6'h3f : 6'h00), r[17:6], r[23:18]);
            end
         end
      end

      // R6 directed: one processor per module, one bus each, none faulted
      cfg_mode = 2'd1; fault = '0;
      step(6'b001111, {2'd0, 2'd0, 2'd3, 2'd2, 2'd1, 2'd0}, 6'b000101);
      chk("R6 all modules served", 64'(gnt_o), 64'b001111);
      // R7 directed: module 3 limited to bus 3; fault bus 3 blocks it
      cfg_mode = 2'd2; fault = 4'b1000;
      step(6'b000001, {10'd0, 2'd3}, 6'd0);
      chk("R7 blocked module", 64'(gnt_o), 64'd0);

      summary();
      $finish;
   end

endmodule